// File: doc/BRIEF.md
# Saturating Decimal Up-Counter

This block is a counter that stores its value as packed BCD digits and counts up in decimal. Each four-bit nibble of the output holds one decimal digit, and the least significant digit sits in the lowest nibble. On each rising clock edge with the enable high, the value goes up by one. A digit that reaches nine returns to zero and passes a carry to the next digit up.

When every digit reads nine, the counter stops and holds that value. It stays there until the asynchronous active-high reset clears it. A parameter sets the number of digits, and the default is four, so the range is 0000 to 9999. A second parameter chooses how the per-digit carries are formed: a serial ripple chain or a parallel lookahead. Both choices give the same count sequence and differ only in logic depth.

Top module: `bcd_sat_counter`

## Requirements
- R1: While `rst` is 1, `count` is forced to all zeros at once, with no clock edge needed, and it stays zero across clock edges for as long as `rst` remains 1.
- R2: `count` is 4*NUM_DIGITS bits wide. Digit i occupies bits [4i+3:4i], with digit 0 the least significant. After reset is released, the value reads zero until the first enabled edge.
- R3: On a rising `clk` edge with `enable` = 1 and `rst` = 0, a value below the maximum becomes the value plus one in decimal.
- R4: On a rising `clk` edge with `enable` = 0, `count` keeps its value.
- R5: A digit changes on an enabled edge only when every lower digit reads 9. A digit that reads 9 and receives that carry becomes 0 (for example 0099 becomes 0100, and 0999 becomes 1000).
- R6: When every digit reads 9, further enabled edges leave `count` unchanged until reset.
- R7: No nibble of `count` ever holds a value above 9.
- R8: Setting CARRY_MODE to ripple or to lookahead produces the same count sequence for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high clear |
| enable | input | 1 | Count one step on this clock edge when 1 |
| count | output | 4*NUM_DIGITS | Packed BCD value, digit 0 in bits [3:0] |

## Verification
The bench builds two copies of the counter, both with NUM_DIGITS = 4. One copy uses the ripple carry network and the other uses the lookahead network. With four digits, the whole range from 0000 to 9999 takes only ten thousand enabled edges. That makes every carry boundary reachable in one sweep, from single-digit wraps to the full 0999 to 1000 chain, along with saturation. Hold cycles, a reset that arrives between edges, and the lockstep comparison of the two carry variants are mixed into that sweep.

// File: rtl/bcd_sat_pkg.sv
`timescale 1ns/1ps
package bcd_sat_pkg;

   localparam int DIGIT_W = 4;
   localparam logic [DIGIT_W-1:0] DIGIT_TOP = 4'd9;

   typedef enum logic {
      CARRY_RIPPLE    = 1'b0,
      CARRY_LOOKAHEAD = 1'b1
   } carry_mode_e;

   function automatic logic [DIGIT_W-1:0] digit_succ(input logic [DIGIT_W-1:0] d);
      if (d == DIGIT_TOP)
         return '0;
      return d + 4'd1;
   endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
`timescale 1ns/1ps
module bcd_digit_cell
   import bcd_sat_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               step,
   output logic [DIGIT_W-1:0] digit,
   output logic               at_top
);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         digit <= '0;
      else if (step)
         digit <= digit_succ(digit);
   end

   assign at_top = (digit == DIGIT_TOP);

   // R7
   digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      digit <= DIGIT_TOP);

   // R5
   digit_step_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> (($past(digit) == DIGIT_TOP) ? (digit == '0) : (digit == $past(digit) + 4'd1)));

   // R4
   digit_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(digit));

endmodule

// File: rtl/bcd_carry_net.sv
`timescale 1ns/1ps
module bcd_carry_net
   import bcd_sat_pkg::*;
#(
   parameter int          NUM_DIGITS = 4,
   parameter carry_mode_e CARRY_MODE = CARRY_RIPPLE
) (
   input  logic                  advance,
   input  logic [NUM_DIGITS-1:0] nines,
   output logic [NUM_DIGITS-1:0] steps,
   output logic                  all_top
);

   if (CARRY_MODE == CARRY_RIPPLE) begin : g_ripple
      logic [NUM_DIGITS:0] prefix;
      assign prefix[0] = 1'b1;
      for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
         assign prefix[i+1] = prefix[i] & nines[i];
         assign steps[i]    = advance & prefix[i];
      end
      assign all_top = prefix[NUM_DIGITS];
   end else begin : g_lookahead
      for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
         localparam logic [NUM_DIGITS-1:0] LOWER = NUM_DIGITS'((64'd1 << i) - 64'd1);
         assign steps[i] = advance & (&(nines | ~LOWER));
      end
      assign all_top = &nines;
   end

endmodule

// File: rtl/bcd_sat_counter.sv
`timescale 1ns/1ps
module bcd_sat_counter
   import bcd_sat_pkg::*;
#(
   parameter int          NUM_DIGITS = 4,
   parameter carry_mode_e CARRY_MODE = CARRY_RIPPLE
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          enable,
   output logic [NUM_DIGITS*DIGIT_W-1:0] count
);

   localparam int COUNT_W = NUM_DIGITS * DIGIT_W;

   if (NUM_DIGITS < 1 || NUM_DIGITS > 16) begin : g_bad_digits
      $error("bcd_sat_counter: NUM_DIGITS must lie in 1..16");
   end

   logic [NUM_DIGITS-1:0] nines;
   logic [NUM_DIGITS-1:0] steps;
   logic                  all_top;
   logic                  advance;

   assign advance = enable & ~all_top;

   bcd_carry_net #(
      .NUM_DIGITS (NUM_DIGITS),
      .CARRY_MODE (CARRY_MODE)
   ) u_carry (
      .advance (advance),
      .nines   (nines),
      .steps   (steps),
      .all_top (all_top)
   );

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
      bcd_digit_cell u_cell (
         .clk    (clk),
         .rst    (rst),
         .step   (steps[i]),
         .digit  (count[i*DIGIT_W +: DIGIT_W]),
         .at_top (nines[i])
      );
   end

   // R4
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !enable |=> $stable(count));

   // R6
   saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (enable && count == {NUM_DIGITS{DIGIT_TOP}}) |=> (count == {NUM_DIGITS{DIGIT_TOP}}));

   // R3
   low_digit_moves_chk: assert property (@(posedge clk) disable iff (rst)
      (enable && count != {NUM_DIGITS{DIGIT_TOP}}) |=> (count[DIGIT_W-1:0] != $past(count[DIGIT_W-1:0])));

   // R5
   lower_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (enable && count[DIGIT_W-1:0] != DIGIT_TOP) |=> (count[COUNT_W-1:DIGIT_W] == $past(count[COUNT_W-1:DIGIT_W])));

endmodule

// File: tb/bcd_sat_counter_test.sv
`timescale 1ns/1ps
module bcd_sat_counter_test;
   import bcd_sat_pkg::*;

   localparam int ND = 4;
   localparam int W  = ND * 4;
   localparam int MAXV = 9999;

   logic clk = 1'b0;
   logic rst = 1'b0;
   logic enable = 1'b0;
   logic [W-1:0] count_r;
   logic [W-1:0] count_l;

   int checks = 0;
   int failures = 0;
   int expv = 0;

   always #5 clk = ~clk;

   bcd_sat_counter #(.NUM_DIGITS(ND), .CARRY_MODE(CARRY_RIPPLE)) uut (
      .clk(clk), .rst(rst), .enable(enable), .count(count_r));

   bcd_sat_counter #(.NUM_DIGITS(ND), .CARRY_MODE(CARRY_LOOKAHEAD)) uut_la (
      .clk(clk), .rst(rst), .enable(enable), .count(count_l));

   function automatic logic [W-1:0] to_bcd(input int v);
      logic [W-1:0] r;
      int t;
      t = v;
      r = '0;
      for (int k = 0; k < ND; k++) begin
         r[k*4 +: 4] = 4'(t % 10);
         t = t / 10;
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_nibbles(input logic [W-1:0] act);
      logic bad;
      bad = 1'b0;
      for (int k = 0; k < ND; k++)
         if (act[k*4 +: 4] > 4'd9) bad = 1'b1;
      checks++;
      if (bad) begin
         failures++;
         $display("FAIL R7 actual=%h expected=all nibbles <= 9", act);
      end
   endtask

   task automatic tick(input logic en);
      enable = en;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #1 rst = 1'b1;
      #2;
      // R1: cleared before any clock edge
      check("R1", count_r, '0);
      check("R1", count_l, '0);
      #9 rst = 1'b0;
      @(posedge clk);
      #1;
      // R2: zero after release
      check("R2", count_r, '0);
      tick(1'b0);
      check("R2", count_r, '0);

      for (int v = 0; v < MAXV; v++) begin
         if (v % 1111 == 0) begin
            tick(1'b0);
            check("R4", count_r, to_bcd(v));
            check("R4", count_l, to_bcd(v));
         end
         tick(1'b1);
         expv = v + 1;
         if (v % 10 == 9)
            check("R5", count_r, to_bcd(expv));
         else
            check("R3", count_r, to_bcd(expv));
         check("R8", count_l, count_r);
         check_nibbles(count_r);
      end

      // R6: saturated value holds on enabled edges
      for (int k = 0; k < 5; k++) begin
         tick(1'b1);
         check("R6", count_r, to_bcd(MAXV));
         check("R6", count_l, to_bcd(MAXV));
      end
      tick(1'b0);
      check("R4", count_r, to_bcd(MAXV));

      // R1: reset in the middle of a cycle
      #2 rst = 1'b1;
      #1;
      check("R1", count_r, '0);
      check("R1", count_l, '0);
      enable = 1'b1;
      @(posedge clk);
      #1;
      check("R1", count_r, '0);
      #3 rst = 1'b0;
      @(posedge clk);
      #1;
      check("R3", count_r, to_bcd(1));
      check("R8", count_l, to_bcd(1));
      tick(1'b0);
      check("R4", count_r, to_bcd(1));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule